// File: doc/BRIEF.md
# Floating-Point Error Interrupt and Ignore Control

This block turns the processor's floating-point error line into two things. It raises an interrupt request toward the system interrupt controller when an error appears. It also drives an output that tells the processor to ignore further numeric exceptions, and it does this only after software has acknowledged the error. Software acknowledges by writing any value to a fixed I/O port.

The error input is active low and asynchronous, so it passes through a synchroniser first. The interrupt request is edge-based: it is raised when the synchronised error becomes active and cleared by the acknowledge write. It is not raised again until the error has gone away and returned. The ignore output is active low. An acknowledge write sets it only while the error is active and reporting is enabled. It is released by the error going away, or by reporting being disabled. Software cannot release it directly.

Top module: `coproc_err_irq`

## Requirements
- R1: After reset, `irq_req` is 0 and `ignore_exc_n` is 1.
- R2: Pulling `fpu_err_n` low sets `irq_req` to 1 on the third rising clock edge after the change: two synchroniser edges, then one latch edge.
- R3: A cycle with `io_wr`=1 and `io_addr`=ERR_PORT (default 0x00F0) clears `irq_req` at that edge. `irq_req` then stays 0 for as long as `fpu_err_n` stays low.
- R4: After `fpu_err_n` goes high and low again, `irq_req` rises again, with the same three-edge latency as in R2.
- R5: A write to ERR_PORT while the synchronised error is active and `report_en` is 1 drives `ignore_exc_n` to 0 at that edge.
- R6: A write to ERR_PORT while the synchronised error is inactive leaves `ignore_exc_n` at 1.
- R7: Once `ignore_exc_n` is 0, it stays 0 through further writes while the error persists. It returns to 1 on the third rising edge after `fpu_err_n` goes high.
- R8: While `report_en` is 0, a write to ERR_PORT leaves `ignore_exc_n` at 1. Dropping `report_en` while `ignore_exc_n` is 0 returns it to 1 on the next edge.
- R9: A write to any address other than ERR_PORT changes neither `irq_req` nor `ignore_exc_n`.
- R10: When the edge that would raise `irq_req` also samples a write to ERR_PORT, `irq_req` is set, because the new error wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fpu_err_n | input | 1 | Floating-point error from the processor, active low, asynchronous |
| report_en | input | 1 | Enables the ignore-exception function |
| io_wr | input | 1 | Single-cycle I/O write strobe |
| io_addr | input | ADDR_W | I/O address that goes with `io_wr` |
| irq_req | output | 1 | Interrupt request to the interrupt controller, active high |
| ignore_exc_n | output | 1 | Ignore numeric exception to the processor, active low |

## Verification
A change on `fpu_err_n` reaches `irq_req` at the third edge, and reaches the release of `ignore_exc_n` at the third edge as well. For each of these, the bench samples one nanosecond after the second edge and expects the old value, then samples again after the third edge and expects the new value. A write has its effect at the edge that samples it. The bench therefore holds `io_wr` for exactly one edge and checks one nanosecond after that edge. Before any write that must find the error active, the bench first waits for the two synchroniser edges to pass.

// File: rtl/cerr_pkg.sv
package cerr_pkg;
  localparam int unsigned CERR_ADDR_W   = 16;
  localparam int unsigned CERR_PORT     = 16'h00F0;
  localparam int unsigned CERR_SYNC_LEN = 2;

  // Status of the latched request / ignore state.
  typedef struct packed {
    logic irq;
    logic ignore;
  } cerr_state_t;
endpackage

// File: rtl/cerr_sync.sv
module cerr_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cerr_irq_latch.sv
module cerr_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic err_s,
  input  logic ack,
  output logic irq
);
  logic prev_q, prev_d;
  logic irq_q, irq_d;
  logic err_rise;

  always_comb begin
    err_rise = err_s & ~prev_q;
    prev_d   = err_s;
    irq_d    = irq_q;
    if (ack)      irq_d = 1'b0;
    if (err_rise) irq_d = 1'b1;   // new error wins over a coinciding clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/cerr_ignore_ctl.sv
module cerr_ignore_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic err_s,
  input  logic report_en,
  input  logic ack,
  output logic ignore
);
  logic ign_q, ign_d;
  logic ign_en;

  always_comb begin
    ign_en = 1'b0;
    ign_d  = ign_q;
    if (!err_s || !report_en) begin
      ign_en = ign_q;
      ign_d  = 1'b0;
    end else if (ack && !ign_q) begin
      ign_en = 1'b1;
      ign_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ign_q <= 1'b0;
    else if (ign_en) ign_q <= ign_d;
  end

  assign ignore = ign_q;
endmodule

// File: rtl/coproc_err_irq.sv
module coproc_err_irq
  import cerr_pkg::*;
#(
  parameter int unsigned ADDR_W   = CERR_ADDR_W,
  parameter int unsigned ERR_PORT = CERR_PORT,
  parameter int unsigned SYNC_LEN = CERR_SYNC_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fpu_err_n,
  input  logic              report_en,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              irq_req,
  output logic              ignore_exc_n
);
  localparam logic [ADDR_W-1:0] PORT_MATCH = ADDR_W'(ERR_PORT);

  logic        rst_core_n;
  logic        err_s;
  logic        ack;
  cerr_state_t st;

  cerr_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_core_n)
  );

  cerr_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_err_sync (
    .clk(clk), .rst_n(rst_core_n), .d(~fpu_err_n), .q(err_s)
  );

  assign ack = io_wr && (io_addr == PORT_MATCH);

  cerr_irq_latch u_irq (
    .clk(clk), .rst_n(rst_core_n), .err_s(err_s), .ack(ack), .irq(st.irq)
  );

  cerr_ignore_ctl u_ign (
    .clk(clk), .rst_n(rst_core_n), .err_s(err_s), .report_en(report_en),
    .ack(ack), .ignore(st.ignore)
  );

  assign irq_req      = st.irq;
  assign ignore_exc_n = ~st.ignore;
endmodule

// File: rtl/cerr_checks.sv
module cerr_checks (
  input logic clk,
  input logic rst_core_n,
  input logic err_s,
  input logic ack,
  input logic report_en,
  input logic irq_req,
  input logic ignore_exc_n
);
  // R7: without an active error, the ignore output is released next edge
  assert_release_on_clear_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    !err_s |=> ignore_exc_n);

  // R8: disabled reporting keeps the ignore output released
  assert_disabled_release_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !report_en |=> ignore_exc_n);

  // R5: acknowledge during an active, enabled error asserts ignore
  assert_ack_sets_ignore_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ack && err_s && report_en) |=> !ignore_exc_n);

  // R7: ignore holds while the error and the enable stay
  assert_ignore_holds_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!ignore_exc_n && err_s && report_en) |=> !ignore_exc_n);

  // R3: the request only drops on an acknowledge
  assert_irq_clear_by_ack_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(irq_req) |-> $past(ack));

  // R2: the request only rises one edge after the error became active
  assert_irq_rise_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(irq_req) |-> ($past(err_s) && !$past(err_s, 2)));
endmodule

bind coproc_err_irq cerr_checks u_cerr_checks (
  .clk(clk), .rst_core_n(rst_core_n), .err_s(err_s), .ack(ack),
  .report_en(report_en), .irq_req(irq_req), .ignore_exc_n(ignore_exc_n)
);

// File: tb/coproc_err_irq_test.sv
module coproc_err_irq_test;
  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] PORT = 16'h00F0;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fpu_err_n;
  logic          report_en;
  logic          io_wr;
  logic [AW-1:0] io_addr;
  logic          irq_req;
  logic          ignore_exc_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  coproc_err_irq uut (
    .clk(clk), .rst_n(rst_n), .fpu_err_n(fpu_err_n), .report_en(report_en),
    .io_wr(io_wr), .io_addr(io_addr), .irq_req(irq_req), .ignore_exc_n(ignore_exc_n)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a);
    io_addr = a; io_wr = 1'b1;
    edges(1);
    io_wr = 1'b0; io_addr = '0;
  endtask

  task automatic go_idle();
    fpu_err_n = 1'b1; report_en = 1'b1;
    edges(4);
    wr(PORT);
    edges(1);
  endtask

  task automatic t_reset();
    check(irq_req, 1'b0, "R1", "irq after reset");
    check(ignore_exc_n, 1'b1, "R1", "ignore after reset");
  endtask

  task automatic t_raise_and_ack();
    go_idle();
    fpu_err_n = 1'b0;
    edges(2);
    check(irq_req, 1'b0, "R2", "irq before third edge");
    edges(1);
    check(irq_req, 1'b1, "R2", "irq at third edge");
    wr(PORT);
    check(irq_req, 1'b0, "R3", "irq cleared by ack");
    check(ignore_exc_n, 1'b0, "R5", "ignore set by ack");
    edges(6);
    check(irq_req, 1'b0, "R3", "irq stays low while error held");
    wr(PORT);
    check(ignore_exc_n, 1'b0, "R7", "ignore holds across second write");
    fpu_err_n = 1'b1;
    edges(2);
    check(ignore_exc_n, 1'b0, "R7", "ignore before release edge");
    edges(1);
    check(ignore_exc_n, 1'b1, "R7", "ignore released at third edge");
  endtask

  task automatic t_rearm();
    go_idle();
    fpu_err_n = 1'b0;
    edges(3);
    wr(PORT);
    fpu_err_n = 1'b1;
    edges(4);
    fpu_err_n = 1'b0;
    edges(2);
    check(irq_req, 1'b0, "R4", "irq before re-raise edge");
    edges(1);
    check(irq_req, 1'b1, "R4", "irq re-raised");
  endtask

  task automatic t_write_idle();
    go_idle();
    wr(PORT);
    check(ignore_exc_n, 1'b1, "R6", "ignore after write with no error");
    edges(2);
    check(ignore_exc_n, 1'b1, "R6", "ignore later with no error");
  endtask

  task automatic t_disabled();
    go_idle();
    report_en = 1'b0;
    fpu_err_n = 1'b0;
    edges(3);
    wr(PORT);
    check(ignore_exc_n, 1'b1, "R8", "ignore with reporting off");
    report_en = 1'b1;
    fpu_err_n = 1'b1;
    edges(4);
    fpu_err_n = 1'b0;
    edges(3);
    wr(PORT);
    check(ignore_exc_n, 1'b0, "R8", "ignore set with reporting on");
    report_en = 1'b0;
    edges(1);
    check(ignore_exc_n, 1'b1, "R8", "ignore released by disable");
    report_en = 1'b1;
  endtask

  task automatic t_other_addr();
    go_idle();
    fpu_err_n = 1'b0;
    edges(3);
    wr(16'h00F1);
    check(irq_req, 1'b1, "R9", "irq after write to other port");
    check(ignore_exc_n, 1'b1, "R9", "ignore after write to other port");
    wr(16'h01F0);
    check(irq_req, 1'b1, "R9", "irq after write to alias port");
    check(ignore_exc_n, 1'b1, "R9", "ignore after write to alias port");
  endtask

  task automatic t_coincide();
    go_idle();
    fpu_err_n = 1'b0;
    edges(2);
    wr(PORT);
    check(irq_req, 1'b1, "R10", "irq set wins over coinciding ack");
    check(ignore_exc_n, 1'b0, "R10", "ignore set on coinciding ack");
  endtask

  initial begin
    rst_n = 1'b0; fpu_err_n = 1'b1; report_en = 1'b1; io_wr = 1'b0; io_addr = '0;
    edges(3);
    t_reset();
    rst_n = 1'b1;
    edges(4);
    t_reset();
    t_raise_and_ack();
    t_rearm();
    t_write_idle();
    t_disabled();
    t_other_addr();
    t_coincide();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule